// File: doc/BRIEF.md
# Pulse-Density Actuator Drive Modulator

This block turns a signed control word for one actuator (focus, radial or sledge) into a single-bit stream whose density of ones follows the word. It uses a first-order error-feedback modulator, so the quantisation error is pushed towards high frequencies. A plain RC low-pass filter on the board can then rebuild an analog drive level. A divider inside the block derives a one-cycle sample strobe from the system clock. Only the strobed cycles move the modulator, so the stream runs at a fixed rate of system clock divided by `RATE_DIV`. With a 4.2336 MHz clock and a divide of 4, that rate is 1.0584 MHz.

The control word is treated as two's complement. Inside the block it is turned into an offset-binary level `u` by inverting its sign bit, so the most negative word gives `u = 0`, zero gives `u = 2^(DW-1)`, and the most positive word gives `u = 2^DW - 1`.

Each strobe adds `u` to a `DW`-bit error register. The carry out of that `DW+1`-bit sum becomes the next output bit, and the low `DW` bits are kept as the new error.

While the active-low reset is low, the output-enable is low, and the pad driver outside the block holds the line in high impedance. After reset is released, the enable rises with the first strobe.

Top module: `pdm_actuator_out`

## Requirements
- R1: While `rst_n` is low, `pdm_oe`, `pdm_bit` and `rate_stb` are all 0, and the error register is loaded with mid-scale `2^(DW-1)`.
- R2: `rate_stb` is high for exactly one clock in every `RATE_DIV` clocks. The first pulse is the `RATE_DIV`-th clock cycle after `rst_n` rises.
- R3: `pdm_oe` rises on the clock edge at which the first strobe after reset is taken, and stays high until the next reset.
- R4: `pdm_bit` changes only on the clock edge that follows a cycle in which `rate_stb` is high.
- R5: With a constant word applied from reset, the number of ones seen after `n` strobes equals `floor((2^(DW-1) + n*u) / 2^DW)`, where `u` is the word with its sign bit inverted, read as unsigned.
- R6: A zero word applied from reset gives the sequence 1, 0, 1, 0, … which is a density of exactly one half.
- R7: The most negative word never produces a one. The most positive word produces exactly one zero in every `2^DW` strobes.
- R8: Changes to `ctrl_word` in cycles where `rate_stb` is low have no effect. Only the value present during a strobe cycle reaches the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | DW | Signed actuator control value |
| rate_stb | output | 1 | Output sample strobe, one clock wide |
| pdm_bit | output | 1 | Pulse-density output bit |
| pdm_oe | output | 1 | Output-enable for the external pad driver; low means high impedance |

## Verification
The bench builds the block with its default parameters: a 10-bit word and a divide of 4, which gives the 1.0584 MHz rate from a 4.2336 MHz clock. At these values one error-register period is 1024 strobes. A run of 1100 strobes at the most positive word therefore reaches the single zero that R7 predicts, and the one-count formula of R5 can be checked after a full wrap of the error register. The random phases change the word on every clock, not only on strobe cycles, so any leak of off-strobe values into the stream shows up as a mismatch against the bench's strobe-sampled expectation.

// File: rtl/pdm_actuator_out.sv
module pdm_actuator_out #(
  parameter int DW       = 10,
  parameter int RATE_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctrl_word,
  output logic          rate_stb,
  output logic          pdm_bit,
  output logic          pdm_oe
);
  localparam int CW = (RATE_DIV > 2) ? $clog2(RATE_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(RATE_DIV - 1);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [CW-1:0] div_q;
  logic [DW-1:0] err_q;
  logic [DW-1:0] level_u;
  logic [DW:0]   sum;

  assign level_u  = {~ctrl_word[DW-1], ctrl_word[DW-2:0]};
  assign sum      = {1'b0, err_q} + {1'b0, level_u};
  assign rate_stb = rst_n && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= MID;
      pdm_bit <= 1'b0;
      pdm_oe  <= 1'b0;
    end else if (rate_stb) begin
      err_q   <= sum[DW-1:0];
      pdm_bit <= sum[DW];
      pdm_oe  <= 1'b1;
    end
  end
endmodule

module pdm_actuator_out_chk #(
  parameter int DW       = 10,
  parameter int RATE_DIV = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ctrl_word,
  input logic          rate_stb,
  input logic          pdm_bit,
  input logic          pdm_oe
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 0;
    else        gap <= rate_stb ? 0 : gap + 1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!pdm_oe && !pdm_bit && !rate_stb);
    end
  end

  // R2
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_stb |-> gap == RATE_DIV - 1);

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_stb |=> !rate_stb);

  // R3
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_stb |=> pdm_oe);

  // R3
  oe_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdm_oe |=> pdm_oe);

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_stb |=> $stable(pdm_bit));

  // R7
  min_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_stb && ctrl_word == MOST_NEG) |=> !pdm_bit);
endmodule

bind pdm_actuator_out pdm_actuator_out_chk #(.DW(DW), .RATE_DIV(RATE_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
  .rate_stb(rate_stb), .pdm_bit(pdm_bit), .pdm_oe(pdm_oe)
);

// File: tb/pdm_actuator_out_tb_top.sv
`timescale 1ns/1ps
module pdm_actuator_out_tb_top;
  localparam int DW   = 10;
  localparam int K    = 4;
  localparam int FULL = 1 << DW;
  localparam int HALF = 1 << (DW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] ctrl_word = '0;
  logic          rate_stb, pdm_bit, pdm_oe;

  int n_cmp = 0, n_bad = 0;
  int acc_m, bc, act_ones;
  bit oe_m, bit_m;
  bit done = 0;

  always #5 clk = ~clk;

  pdm_actuator_out #(.DW(DW), .RATE_DIV(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .rate_stb(rate_stb), .pdm_bit(pdm_bit), .pdm_oe(pdm_oe)
  );

  function automatic int to_u(logic [DW-1:0] w);
    return int'({~w[DW-1], w[DW-2:0]});
  endfunction

  function automatic int ones_expect(int u, int n);
    return (HALF + n * u) / FULL;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 oe in reset", pdm_oe, 0);
      chk("R1 bit in reset", pdm_bit, 0);
      chk("R1 stb in reset", rate_stb, 0);
    end
    rst_n = 1'b1;
    acc_m = HALF; oe_m = 0; bit_m = 0; bc = 0; act_ones = 0;
  endtask

  // mode 0: constant val; 1: random every clock; 2: val on strobe cycles, noise elsewhere
  task automatic run(int mode, logic [DW-1:0] val, int nstb);
    bit prev_stb = 0;
    for (int i = 0; i <= nstb * K; i++) begin
      bit stb_e = (bc % K) == (K - 1);
      logic [DW-1:0] d;
      if (prev_stb) act_ones += int'(pdm_bit);
      chk("R2 strobe", rate_stb, stb_e);
      chk("R3 enable", pdm_oe, oe_m);
      chk("R4/R8 bit", pdm_bit, bit_m);
      if (i == nstb * K) break;
      case (mode)
        0:       d = val;
        1:       d = DW'($urandom);
        default: d = stb_e ? val : DW'($urandom);
      endcase
      ctrl_word = d;
      if (stb_e) begin
        int s = acc_m + to_u(d);
        bit_m = s >= FULL;
        acc_m = s % FULL;
        oe_m  = 1;
      end
      prev_stb = stb_e;
      @(negedge clk);
      bc++;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R2 first strobe timing and R3 enable rise
    ctrl_word = '0;
    for (int i = 1; i <= K; i++) begin
      @(negedge clk);
      bc++;
      if (i == K - 1) chk("R2 first strobe", rate_stb, 1);
      if (i == K - 1) chk("R3 oe before strobe", pdm_oe, 0);
      if (i == K)     chk("R3 oe after strobe", pdm_oe, 1);
    end

    // R6 zero input alternates
    do_reset();
    ctrl_word = '0;
    for (int s = 0; s < 8; s++) begin
      repeat (K) @(negedge clk);
      chk("R6 alternation", pdm_bit, (s % 2 == 0) ? 1 : 0);
    end

    // R5 / R7 constant words from reset
    do_reset();
    run(0, {1'b0, {(DW-1){1'b1}}}, 1100);
    chk("R7 max ones", act_ones, ones_expect(FULL - 1, 1100));
    chk("R7 one zero", 1100 - act_ones, 1);

    do_reset();
    run(0, {1'b1, {(DW-1){1'b0}}}, 300);
    chk("R7 min ones", act_ones, 0);

    do_reset();
    run(0, '0, 200);
    chk("R6 half density", act_ones, 100);

    for (int t = 0; t < 4; t++) begin
      logic [DW-1:0] v = DW'($urandom);
      do_reset();
      run(0, v, 400 + t * 97);
      chk("R5 ones count", act_ones, ones_expect(to_u(v), 400 + t * 97));
    end

    // R8 off-strobe noise ignored
    for (int t = 0; t < 3; t++) begin
      logic [DW-1:0] v = DW'($urandom);
      do_reset();
      run(2, v, 500);
      chk("R8 ones under noise", act_ones, ones_expect(to_u(v), 500));
    end

    // free random stream, then mid-stream reset
    do_reset();
    run(1, '0, 2000);
    do_reset();
    run(1, '0, 200);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule